// File: doc/BRIEF.md
# Correlator Accumulator Readout Bank

This block is the read side of a multi-channel correlator's result registers. Each channel owns four signed accumulator results: in-phase and quadrature for the tracking arm, and in-phase and quadrature for the prompt arm. When the correlation engine finishes an integration period on a channel, it pulses that channel's dump line and presents the four sums. The bank captures them, marks the channel as holding fresh data and raises an accumulation interrupt.

A host reads results through a byte-wide address and a one-cycle read strobe. The answer arrives one clock later with a valid pulse. Each channel occupies four consecutive addresses. The quadrature prompt word is meant to be read last in a channel's group, and reading it clears that channel's fresh-data bit. An address outside the result window returns zero and pulses an error line. The interrupt is cleared by a separate acknowledge input, and the acknowledge does not touch the per-channel status bits.

Top module: `corr_readout_bank`

## Requirements
- R1: After reset, `rd_data`, `rd_valid`, `rd_err`, `new_data` and `accum_int` are all zero, and every stored result reads as zero.
- R2: Channel n (0..11) occupies addresses 0x84+4n to 0x87+4n. Offset 0 returns in-phase track, 1 quadrature track, 2 in-phase prompt and 3 quadrature prompt. The data appears on `rd_data` one clock after the strobe, together with a one-cycle `rd_valid` pulse.
- R3: A read of any address below 0x84 or above 0xB3 returns `rd_data` = 0 and pulses `rd_err` for exactly one cycle, with `rd_valid` low.
- R4: A pulse on `dump_vec[n]` captures channel n's four input words, and `new_data[n]` is set one clock later.
- R5: Any dump raises `accum_int` one clock later. It stays high until it is acknowledged.
- R6: A read at offset 3 of channel n clears `new_data[n]` one clock later. Reads at offsets 0 to 2 leave the bit unchanged.
- R7: If channel n dumps in the same cycle as its offset-3 read, `new_data[n]` stays set. The read returns the value held before the dump, and the next read returns the new value.
- R8: `int_ack` clears `accum_int` one clock later and leaves `new_data` unchanged. A dump in the same cycle as the acknowledge keeps `accum_int` set.
- R9: A read, legal or illegal, changes no status bit other than the one for the channel whose offset-3 word is read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dump_vec | input | 12 | Per-channel dump pulse |
| dump_i_trk | input | 192 | In-phase track sums, 16 bits per channel, channel 0 in the low bits |
| dump_q_trk | input | 192 | Quadrature track sums, same packing |
| dump_i_prm | input | 192 | In-phase prompt sums, same packing |
| dump_q_prm | input | 192 | Quadrature prompt sums, same packing |
| rd_en | input | 1 | One-cycle read strobe |
| rd_addr | input | 8 | Read byte address |
| int_ack | input | 1 | Accumulation interrupt acknowledge |
| rd_data | output | 16 | Registered signed read result |
| rd_valid | output | 1 | Pulses with legal read data |
| rd_err | output | 1 | Pulses for an illegal read address |
| new_data | output | 12 | Per-channel fresh-data status |
| accum_int | output | 1 | Accumulation interrupt flag |

## Verification
Every result of this block arrives exactly one clock after its cause. This holds for read data with its valid or error pulse, for the status set after a dump, for the status clear after a quadrature-prompt read, and for the interrupt rise and clear. The bench drives each stimulus just after a falling edge and keeps it for one rising edge. It then compares the outputs at the next falling edge, half a period after they change, and at the following falling edge where a pulse must have ended. In the collision case the bench samples the read data in the same cycle the dump lands, which shows the pre-dump value and the surviving status bit together.

// File: rtl/corr_rb_pkg.sv
package corr_rb_pkg;
   // Word select within a channel group; offset 3 is the final word of a group
   typedef enum logic [1:0] {
      F_I_TRK = 2'd0,
      F_Q_TRK = 2'd1,
      F_I_PRM = 2'd2,
      F_Q_PRM = 2'd3
   } corr_field_e;

   localparam int WORDS_PER_CH = 4;
endpackage

// File: rtl/corr_rb_decode.sv
module corr_rb_decode
   import corr_rb_pkg::*;
#(
   parameter int          NUM_CH    = 12,
   parameter int          ADDR_W    = 8,
   parameter int          CH_W      = 4,
   parameter logic [7:0]  BASE_ADDR = 8'h84
) (
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic              hit,
   output logic [CH_W-1:0]   ch_sel,
   output corr_field_e       fld_sel,
   output logic [NUM_CH-1:0] clr_vec
);
   localparam int SPAN = NUM_CH * WORDS_PER_CH;

   logic [ADDR_W:0] off_full;

   always_comb begin
      off_full = {1'b0, rd_addr} - (ADDR_W+1)'(BASE_ADDR);
      hit      = !off_full[ADDR_W] && (off_full < (ADDR_W+1)'(SPAN));
      ch_sel   = hit ? off_full[CH_W+1:2] : '0;
      fld_sel  = corr_field_e'(off_full[1:0]);
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_clr
      assign clr_vec[g] = rd_en && hit && (fld_sel == F_Q_PRM) && (ch_sel == CH_W'(g));
   end
endmodule

// File: rtl/corr_rb_store.sv
module corr_rb_store
   import corr_rb_pkg::*;
#(
   parameter int NUM_CH = 12,
   parameter int ACC_W  = 16
) (
   input  logic                                      clk,
   input  logic                                      rst_n,
   input  logic [NUM_CH-1:0]                         dump_vec,
   input  logic [NUM_CH*ACC_W-1:0]                   dump_i_trk,
   input  logic [NUM_CH*ACC_W-1:0]                   dump_q_trk,
   input  logic [NUM_CH*ACC_W-1:0]                   dump_i_prm,
   input  logic [NUM_CH*ACC_W-1:0]                   dump_q_prm,
   output logic [NUM_CH-1:0][WORDS_PER_CH-1:0][ACC_W-1:0] acc_q
);
   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            acc_q[g] <= '0;
         end else if (dump_vec[g]) begin
            acc_q[g][F_I_TRK] <= dump_i_trk[g*ACC_W +: ACC_W];
            acc_q[g][F_Q_TRK] <= dump_q_trk[g*ACC_W +: ACC_W];
            acc_q[g][F_I_PRM] <= dump_i_prm[g*ACC_W +: ACC_W];
            acc_q[g][F_Q_PRM] <= dump_q_prm[g*ACC_W +: ACC_W];
         end
      end
   end
endmodule

// File: rtl/corr_rb_status.sv
module corr_rb_status #(
   parameter int NUM_CH = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] dump_vec,
   input  logic [NUM_CH-1:0] clr_vec,
   input  logic              int_ack,
   output logic [NUM_CH-1:0] new_data,
   output logic              accum_int
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         new_data  <= '0;
         accum_int <= 1'b0;
      end else begin
         // set after clear: a dump wins over a same-cycle read clear
         new_data  <= (new_data & ~clr_vec) | dump_vec;
         accum_int <= (accum_int && !int_ack) || (|dump_vec);
      end
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      p_dump_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
         dump_vec[g] |=> new_data[g]);
      p_rise_needs_dump_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !new_data[g] ##1 new_data[g] |-> $past(dump_vec[g]));
      p_qprm_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
         clr_vec[g] && !dump_vec[g] |=> !new_data[g]);
      p_dump_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
         clr_vec[g] && dump_vec[g] |=> new_data[g]);
   end

   p_int_on_dump_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (|dump_vec) |=> accum_int);
   p_ack_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack && !(|dump_vec) |=> !accum_int);
   p_ack_keeps_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
      int_ack && !(|dump_vec) && !(|clr_vec) |=> $stable(new_data));
endmodule

// File: rtl/corr_readout_bank.sv
module corr_readout_bank
   import corr_rb_pkg::*;
#(
   parameter int          NUM_CH    = 12,
   parameter int          ACC_W     = 16,
   parameter int          ADDR_W    = 8,
   parameter logic [7:0]  BASE_ADDR = 8'h84
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_CH-1:0]       dump_vec,
   input  logic [NUM_CH*ACC_W-1:0] dump_i_trk,
   input  logic [NUM_CH*ACC_W-1:0] dump_q_trk,
   input  logic [NUM_CH*ACC_W-1:0] dump_i_prm,
   input  logic [NUM_CH*ACC_W-1:0] dump_q_prm,
   input  logic                    rd_en,
   input  logic [ADDR_W-1:0]       rd_addr,
   input  logic                    int_ack,
   output logic [ACC_W-1:0]        rd_data,
   output logic                    rd_valid,
   output logic                    rd_err,
   output logic [NUM_CH-1:0]       new_data,
   output logic                    accum_int
);
   localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int SPAN = NUM_CH * WORDS_PER_CH;

   // elaboration-time parameter checks
   if (NUM_CH < 1) begin : g_bad_ch
      $error("NUM_CH must be at least 1");
   end
   if (ACC_W < 2) begin : g_bad_w
      $error("ACC_W must be at least 2");
   end
   if (ADDR_W > 8 || ADDR_W < CH_W + 2) begin : g_bad_aw
      $error("ADDR_W must lie between CH_W+2 and 8");
   end
   if (BASE_ADDR[1:0] != 2'b00) begin : g_bad_align
      $error("BASE_ADDR must be aligned to a channel group");
   end
   if (int'(BASE_ADDR) + SPAN > (1 << ADDR_W)) begin : g_bad_span
      $error("result window exceeds the address space");
   end

   logic                                          hit;
   logic [CH_W-1:0]                               ch_sel;
   corr_field_e                                   fld_sel;
   logic [NUM_CH-1:0]                             clr_vec;
   logic [NUM_CH-1:0][WORDS_PER_CH-1:0][ACC_W-1:0] acc_q;

   corr_rb_decode #(
      .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_W(CH_W), .BASE_ADDR(BASE_ADDR)
   ) u_dec (
      .rd_en(rd_en), .rd_addr(rd_addr), .hit(hit),
      .ch_sel(ch_sel), .fld_sel(fld_sel), .clr_vec(clr_vec)
   );

   corr_rb_store #(.NUM_CH(NUM_CH), .ACC_W(ACC_W)) u_store (
      .clk(clk), .rst_n(rst_n), .dump_vec(dump_vec),
      .dump_i_trk(dump_i_trk), .dump_q_trk(dump_q_trk),
      .dump_i_prm(dump_i_prm), .dump_q_prm(dump_q_prm),
      .acc_q(acc_q)
   );

   corr_rb_status #(.NUM_CH(NUM_CH)) u_stat (
      .clk(clk), .rst_n(rst_n), .dump_vec(dump_vec), .clr_vec(clr_vec),
      .int_ack(int_ack), .new_data(new_data), .accum_int(accum_int)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data  <= '0;
         rd_valid <= 1'b0;
         rd_err   <= 1'b0;
      end else begin
         rd_valid <= rd_en && hit;
         rd_err   <= rd_en && !hit;
         if (rd_en) begin
            rd_data <= hit ? acc_q[ch_sel][fld_sel] : '0;
         end
      end
   end

   p_legal_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && hit |=> rd_valid && !rd_err);
   p_pulses_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && rd_err));
   p_illegal_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en && !hit |=> rd_err && !rd_valid && (rd_data == '0));
   p_err_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_err && !$past(rd_en && !hit, 1) |-> 1'b0);
   p_no_read_no_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> !rd_valid && !rd_err);
endmodule

// File: tb/corr_readout_bank_test.sv
module corr_readout_bank_test;
   localparam int NCH = 12;
   localparam int W   = 16;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [NCH-1:0]     dump_vec = '0;
   logic [NCH*W-1:0]   d_it = '0, d_qt = '0, d_ip = '0, d_qp = '0;
   logic               rd_en = 1'b0;
   logic [7:0]         rd_addr = '0;
   logic               int_ack = 1'b0;
   logic [W-1:0]       rd_data;
   logic               rd_valid, rd_err;
   logic [NCH-1:0]     new_data;
   logic               accum_int;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [W-1:0] mdl [NCH][4];

   corr_readout_bank uut (
      .clk(clk), .rst_n(rst_n), .dump_vec(dump_vec),
      .dump_i_trk(d_it), .dump_q_trk(d_qt), .dump_i_prm(d_ip), .dump_q_prm(d_qp),
      .rd_en(rd_en), .rd_addr(rd_addr), .int_ack(int_ack),
      .rd_data(rd_data), .rd_valid(rd_valid), .rd_err(rd_err),
      .new_data(new_data), .accum_int(accum_int)
   );

   always #4 clk = ~clk;

   function automatic logic [W-1:0] pat(int c, int f, int k);
      return W'(c * 1000 - f * 333 + k * 71 - 5000);
   endfunction

   task automatic chk(bit ok, string req, longint got, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s got=%0h exp=%0h", req, got, exp);
      end
   endtask

   task automatic load_bus(int c, int k);
      d_it[c*W +: W] = pat(c, 0, k);
      d_qt[c*W +: W] = pat(c, 1, k);
      d_ip[c*W +: W] = pat(c, 2, k);
      d_qp[c*W +: W] = pat(c, 3, k);
   endtask

   task automatic mdl_upd(int c, int k);
      for (int f = 0; f < 4; f++) mdl[c][f] = pat(c, f, k);
   endtask

   // dump one channel; status visible at the following falling edge
   task automatic do_dump(int c, int k);
      load_bus(c, k);
      dump_vec[c] = 1'b1;
      @(negedge clk);
      dump_vec = '0;
      mdl_upd(c, k);
   endtask

   // one strobe, result checked one clock later
   task automatic rd_chk(logic [7:0] a, logic [W-1:0] exp, bit ev, bit ee, string req);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      chk(rd_data == exp, req, rd_data, exp);
      chk(rd_valid == ev, req, rd_valid, ev);
      chk(rd_err == ee, req, rd_err, ee);
   endtask

   task automatic t_reset;
      chk(rd_data == 0 && !rd_valid && !rd_err, "R1 outputs", {rd_data, rd_valid, rd_err}, 0);
      chk(new_data == 0, "R1 new_data", new_data, 0);
      chk(!accum_int, "R1 accum_int", accum_int, 0);
      rd_chk(8'h84 + 8'd47, 16'h0, 1'b1, 1'b0, "R1 stored zero");
   endtask

   task automatic t_dump;
      do_dump(0, 1);
      chk(new_data == 12'h001, "R4 bit0", new_data, 12'h001);
      chk(accum_int, "R5 int raised", accum_int, 1);
      do_dump(5, 1);
      do_dump(11, 1);
      chk(new_data == 12'h821, "R4 bits 0 5 11", new_data, 12'h821);
   endtask

   task automatic t_map;
      for (int c = 0; c < NCH; c++)
         for (int f = 0; f < 3; f++)
            rd_chk(8'(8'h84 + 4*c + f), mdl[c][f], 1'b1, 1'b0, "R2 map");
      chk(new_data == 12'h821, "R6 offsets 0-2 keep status", new_data, 12'h821);
      rd_chk(8'h84 + 8'd23, mdl[5][3], 1'b1, 1'b0, "R2 qprm ch5");
      chk(new_data == 12'h801, "R6 clear ch5 / R9 others kept", new_data, 12'h801);
      rd_chk(8'h84 + 8'd47, mdl[11][3], 1'b1, 1'b0, "R2 qprm ch11");
      chk(new_data == 12'h001, "R6 clear ch11", new_data, 12'h001);
   endtask

   task automatic t_illegal;
      logic [7:0] bad [4] = '{8'h83, 8'hB4, 8'h00, 8'hFF};
      foreach (bad[i]) begin
         rd_chk(bad[i], 16'h0, 1'b0, 1'b1, "R3 illegal");
         @(negedge clk);
         chk(!rd_err, "R3 err one cycle", rd_err, 0);
      end
      chk(new_data == 12'h001, "R9 illegal keeps status", new_data, 12'h001);
      rd_chk(8'h84, mdl[0][0], 1'b1, 1'b0, "R2 low edge");
      rd_chk(8'hB3, mdl[11][3], 1'b1, 1'b0, "R2 high edge");
   endtask

   task automatic t_ack;
      int_ack = 1'b1;
      @(negedge clk);
      int_ack = 1'b0;
      chk(!accum_int, "R8 ack clears", accum_int, 0);
      chk(new_data == 12'h001, "R8 ack keeps status", new_data, 12'h001);
      load_bus(7, 2);
      dump_vec[7] = 1'b1; int_ack = 1'b1;
      @(negedge clk);
      dump_vec = '0; int_ack = 1'b0;
      mdl_upd(7, 2);
      chk(accum_int, "R8 dump beats ack", accum_int, 1);
      chk(new_data == 12'h081, "R4 ch7 set", new_data, 12'h081);
   endtask

   task automatic t_collide;
      logic [W-1:0] old;
      do_dump(3, 3);
      old = mdl[3][3];
      load_bus(3, 4);
      dump_vec[3] = 1'b1;
      rd_en = 1'b1; rd_addr = 8'h84 + 8'd15;
      @(negedge clk);
      dump_vec = '0; rd_en = 1'b0;
      mdl_upd(3, 4);
      chk(rd_data == old, "R7 old data returned", rd_data, old);
      chk(new_data[3], "R7 set wins", new_data[3], 1);
      rd_chk(8'h84 + 8'd15, mdl[3][3], 1'b1, 1'b0, "R7 new data");
      chk(!new_data[3], "R7 later clear", new_data[3], 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      for (int c = 0; c < NCH; c++) for (int f = 0; f < 4; f++) mdl[c][f] = '0;
      t_reset();
      t_dump();
      t_map();
      t_illegal();
      t_ack();
      t_collide();
      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
      end
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog got=hung exp=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
      end
      $finish;
   end
endmodule